// File: doc/BRIEF.md
# Load-Use Interlock Unit

This unit sits beside the issue/decode stage (II) of a five-stage in-order integer pipeline (fetch, II, EX, MM, WB). Every cycle it compares the source registers of the instruction in II against the destination of the instruction in EX. It tells the pipeline whether II must be held. When II is held and EX must receive an empty slot, it also signals that a bubble is needed.

Producers fall into two groups by class code. The first group is early producers, whose result can be forwarded at the end of EX. The second group is late producers (load, multiply, multiply-accumulate, divide), whose result exists only at the end of MM. Each consumer operand carries a flag that says whether that operand is read at EX or only at MM. A store's data and a MAC accumulator are examples of operands read only at MM. Forwarding from MM or WB covers a late-read operand, so only early-read operands can trigger the one-cycle load-use stall. A divide stays in EX for a configurable number of cycles, and the unit holds II for that whole time.

Top module: `load_use_interlock`

## Requirements
- R1: After reset, with no valid instruction in II, `stall_o` and `bubble_o` are both 0.
- R2: If a late producer is in EX (class codes 1 load, 2 multiply, 3 MAC, 4 divide) and a valid II instruction has a valid operand flagged as read at EX (late flag 0) whose register equals that producer's nonzero, valid destination, then `stall_o` and `bubble_o` are both 1.
- R3: A load-use stall lasts exactly one cycle. Because EX then holds a bubble, `stall_o` and `bubble_o` are both 0 in the following cycle even when the II inputs are unchanged.
- R4: An operand whose late flag is 1 (read only at MM) never raises a stall, even when it matches a late producer's destination.
- R5: Producers with class codes 0 (ALU), 5 (store), 6 (branch) and 7 (ALU with shift) never raise a stall.
- R6: A producer whose destination is register 0, or whose destination-valid flag is 0, never raises a stall.
- R7: Operands whose valid bit is 0, and II slots whose valid bit is 0, never raise a stall, whatever register numbers they carry.
- R8: Once a divide (class 4) enters EX, `stall_o` is 1 and `bubble_o` is 0 for the first DIV_CYC-1 cycles it occupies EX.
- R9: In the last cycle a divide occupies EX, the load-use rule of R2 applies to it, so a bubble is produced only after the multi-cycle hold has ended.
- R10: `bubble_o` is never 1 unless `stall_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ii_valid_i | input | 1 | II holds a valid instruction |
| ii_cls_i | input | 3 | Class code of the II instruction |
| ii_dst_i | input | RW | Destination register of the II instruction |
| ii_dst_vld_i | input | 1 | II instruction writes a register |
| ii_src_i | input | NSRC*RW | Source registers, slot k in bits [k*RW +: RW] |
| ii_src_vld_i | input | NSRC | Per-slot operand valid |
| ii_src_late_i | input | NSRC | Per-slot flag: operand read only at MM |
| stall_o | output | 1 | Hold fetch and II this cycle |
| bubble_o | output | 1 | Insert an empty slot into EX this cycle |

## Verification
The bench builds the unit with 3-bit register numbers (8 registers), two operand slots and a 4-cycle divide. This makes a full sweep practical over every class code, every destination with both valid settings, every source register, both late flags and both slots, while the other slot carries an invalid operand that matches the destination. The short divide keeps every divide scenario to a few cycles, yet still exercises the whole hold window and the load-use check on its final cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    CLS_ALU       = 3'd0,
    CLS_LOAD      = 3'd1,
    CLS_MUL       = 3'd2,
    CLS_MAC       = 3'd3,
    CLS_DIV       = 3'd4,
    CLS_STORE     = 3'd5,
    CLS_BRANCH    = 3'd6,
    CLS_ALU_SHIFT = 3'd7
  } iclass_e;

  // result only available at end of MM
  function automatic logic is_late_producer(iclass_e c);
    return (c == CLS_LOAD) || (c == CLS_MUL) || (c == CLS_MAC) || (c == CLS_DIV);
  endfunction

  function automatic logic is_multicycle(iclass_e c);
    return c == CLS_DIV;
  endfunction
endpackage

// File: rtl/hz_ex_track.sv
module hz_ex_track import hz_pkg::*; #(
  parameter int RW      = 5,
  parameter int DIV_CYC = 34,
  localparam int CW     = (DIV_CYC > 2) ? $clog2(DIV_CYC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bubble_i,
  input  logic          ii_valid_i,
  input  logic [2:0]    ii_cls_i,
  input  logic [RW-1:0] ii_dst_i,
  input  logic          ii_dst_vld_i,
  output logic          ex_vld_o,
  output logic          ex_late_o,
  output logic [RW-1:0] ex_dst_o,
  output logic          ex_dst_vld_o,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;
  iclass_e       cls_q;

  assign busy_o    = (cnt_q != '0);
  assign ex_late_o = is_late_producer(cls_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      cls_q        <= CLS_ALU;
      ex_vld_o     <= 1'b0;
      ex_dst_o     <= '0;
      ex_dst_vld_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (bubble_i) begin
      ex_vld_o     <= 1'b0;
      ex_dst_vld_o <= 1'b0;
    end else begin
      ex_vld_o     <= ii_valid_i;
      cls_q        <= iclass_e'(ii_cls_i);
      ex_dst_o     <= ii_dst_i;
      ex_dst_vld_o <= ii_valid_i & ii_dst_vld_i;
      cnt_q        <= (ii_valid_i && is_multicycle(iclass_e'(ii_cls_i)))
                      ? CW'(DIV_CYC - 1) : '0;
    end
  end
endmodule

// File: rtl/hz_dep_match.sv
module hz_dep_match #(
  parameter int RW   = 5,
  parameter int NSRC = 3
) (
  input  logic [NSRC*RW-1:0] src_i,
  input  logic [NSRC-1:0]    src_vld_i,
  input  logic [NSRC-1:0]    src_late_i,
  input  logic [RW-1:0]      dst_i,
  input  logic               dst_vld_i,
  output logic               hit_o
);
  logic [NSRC-1:0] hit_v;
  logic            dst_ok;

  assign dst_ok = dst_vld_i && (dst_i != '0);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    // late-read operands are covered by MM/WB forwarding
    assign hit_v[k] = dst_ok && src_vld_i[k] && !src_late_i[k] &&
                      (src_i[k*RW +: RW] == dst_i);
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int RW      = 5,
  parameter int NSRC    = 3,
  parameter int DIV_CYC = 34
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ii_valid_i,
  input  logic [2:0]         ii_cls_i,
  input  logic [RW-1:0]      ii_dst_i,
  input  logic               ii_dst_vld_i,
  input  logic [NSRC*RW-1:0] ii_src_i,
  input  logic [NSRC-1:0]    ii_src_vld_i,
  input  logic [NSRC-1:0]    ii_src_late_i,
  output logic               stall_o,
  output logic               bubble_o
);
  logic          ex_vld, ex_late, ex_dst_vld, ex_busy, dep_hit, lu_stall;
  logic [RW-1:0] ex_dst;

  hz_ex_track #(.RW(RW), .DIV_CYC(DIV_CYC)) u_ex (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bubble_i    (lu_stall),
    .ii_valid_i  (ii_valid_i),
    .ii_cls_i    (ii_cls_i),
    .ii_dst_i    (ii_dst_i),
    .ii_dst_vld_i(ii_dst_vld_i),
    .ex_vld_o    (ex_vld),
    .ex_late_o   (ex_late),
    .ex_dst_o    (ex_dst),
    .ex_dst_vld_o(ex_dst_vld),
    .busy_o      (ex_busy)
  );

  hz_dep_match #(.RW(RW), .NSRC(NSRC)) u_dep (
    .src_i     (ii_src_i),
    .src_vld_i (ii_src_vld_i),
    .src_late_i(ii_src_late_i),
    .dst_i     (ex_dst),
    .dst_vld_i (ex_dst_vld),
    .hit_o     (dep_hit)
  );

  // divide hold wins over load-use
  assign lu_stall = ii_valid_i && ex_vld && ex_late && !ex_busy && dep_hit;
  assign stall_o  = ex_busy | lu_stall;
  assign bubble_o = lu_stall;
endmodule

module hz_interlock_chk #(
  parameter int RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ii_valid_i,
  input logic          stall_o,
  input logic          bubble_o,
  input logic          busy_i,
  input logic [RW-1:0] ex_dst_i
);
  a_r10_bubble_needs_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> stall_o);
  a_r3_single_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> !bubble_o);
  a_r8_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (stall_o && !bubble_o));
  a_r6_no_zero_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (ex_dst_i != '0));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ii_valid_i |-> !bubble_o);
endmodule

bind load_use_interlock hz_interlock_chk #(.RW(RW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ii_valid_i(ii_valid_i),
  .stall_o   (stall_o),
  .bubble_o  (bubble_o),
  .busy_i    (ex_busy),
  .ex_dst_i  (ex_dst)
);

// File: tb/load_use_interlock_bench.sv
module load_use_interlock_bench;
  localparam int RW = 3, NSRC = 2, DIV_CYC = 4;

  logic               clk = 1'b0, rst_ni = 1'b0;
  logic               ii_valid_i = 1'b0, ii_dst_vld_i = 1'b0;
  logic [2:0]         ii_cls_i = '0;
  logic [RW-1:0]      ii_dst_i = '0;
  logic [NSRC*RW-1:0] ii_src_i = '0;
  logic [NSRC-1:0]    ii_src_vld_i = '0, ii_src_late_i = '0;
  logic               stall_o, bubble_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_use_interlock #(.RW(RW), .NSRC(NSRC), .DIV_CYC(DIV_CYC)) u_load_use_interlock (
    .clk_i(clk), .rst_ni(rst_ni), .ii_valid_i(ii_valid_i), .ii_cls_i(ii_cls_i),
    .ii_dst_i(ii_dst_i), .ii_dst_vld_i(ii_dst_vld_i), .ii_src_i(ii_src_i),
    .ii_src_vld_i(ii_src_vld_i), .ii_src_late_i(ii_src_late_i),
    .stall_o(stall_o), .bubble_o(bubble_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
      finish_run();
    end
  end

  task automatic check(string tag, logic exp_s, logic exp_b);
    n_chk++;
    if (stall_o !== exp_s || bubble_o !== exp_b) begin
      n_bad++;
      $display("FAIL %s: actual stall=%b bubble=%b expected stall=%b bubble=%b",
               tag, stall_o, bubble_o, exp_s, exp_b);
    end
  endtask

  task automatic drive_idle();
    ii_valid_i = 0; ii_cls_i = '0; ii_dst_i = '0; ii_dst_vld_i = 0;
    ii_src_i = '0; ii_src_vld_i = '0; ii_src_late_i = '0;
  endtask

  task automatic scenario(int cls, int dst, bit dv, int sreg, bit late, int slot, bit cvalid);
    bit late_prod, dep, expv;
    string tag;
    @(negedge clk); drive_idle();
    repeat (DIV_CYC + 1) @(negedge clk);
    ii_valid_i = 1; ii_cls_i = 3'(cls); ii_dst_i = RW'(dst); ii_dst_vld_i = dv;
    @(negedge clk);
    ii_valid_i = cvalid; ii_cls_i = 3'd0; ii_dst_vld_i = 0; ii_dst_i = '0;
    ii_src_i[slot*RW +: RW]     = RW'(sreg);
    ii_src_i[(1-slot)*RW +: RW] = RW'(dst);
    ii_src_vld_i  = '0; ii_src_vld_i[slot] = 1'b1;
    ii_src_late_i = '0; ii_src_late_i[slot] = late;
    #2;
    late_prod = (cls >= 1 && cls <= 4);
    dep  = cvalid && dv && dst != 0 && !late && sreg == dst;
    expv = late_prod && dep;
    if (cls == 4) begin
      for (int k = 0; k < DIV_CYC - 1; k++) begin
        check("R8 divide hold", 1'b1, 1'b0);
        @(negedge clk); #2;
      end
      tag = "R9 divide final cycle";
    end else if (expv) tag = "R2 load-use";
    else if (!late_prod) tag = "R5 early producer";
    else if (!dv || dst == 0) tag = "R6 zero/no dest";
    else if (late) tag = "R4 late operand";
    else tag = "R7 no valid match";
    check(tag, expv, expv);
    if (expv) begin
      @(negedge clk); #2;
      check("R3 single stall", 1'b0, 1'b0);
    end
  endtask

  initial begin
    drive_idle();
    #25; #2;
    check("R1 reset", 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    check("R1 idle after reset", 1'b0, 1'b0);
    for (int cls = 0; cls < 8; cls++)
      for (int dst = 0; dst < 8; dst++)
        for (int dv = 0; dv < 2; dv++)
          for (int sreg = 0; sreg < 8; sreg++)
            for (int late = 0; late < 2; late++)
              for (int slot = 0; slot < 2; slot++)
                scenario(cls, dst, dv[0], sreg, late[0], slot, 1'b1);
    // R7: invalid II slot with an exact early match
    for (int cls = 1; cls < 5; cls++)
      scenario(cls, 5, 1'b1, 5, 1'b0, 0, 1'b0);
    // R10 covered by every check above (bubble only with stall)
    finish_run();
  end
endmodule